// File: doc/BRIEF.md
# Interrupt Pin Intake and Delivery Dispatcher

This block watches a bank of interrupt input pins and turns their activity into delivery requests for a downstream interrupt router. Each pin has its own routing entry: vector, destination, destination mode, delivery mode, trigger mode, input polarity and a mask bit. For every pin the block keeps a request-seen bit that follows the pin's effective level. It also keeps a remote-busy bit for level-triggered pins, which blocks repeated delivery of a level source until its entry is rewritten.

Pins that need service are queued as pending. The lowest-numbered pending pin is moved into a registered output slot. The slot holds its request until the consumer accepts it with a valid/ready handshake. If a pin asserts while a delivery for it cannot be queued, the block pulses a per-pin coalesced flag. Rewriting an entry clears its remote-busy bit. If the rewritten entry is an unmasked level entry whose input is already asserted, it is queued straight away. Pin 0 is always sent in physical mode to a boot destination supplied on a port.

Top module: `irq_pin_dispatch`

## Requirements
- R1: A pin's effective level is its raw input XOR the entry's polarity bit, and its request-seen bit takes the effective level at each clock edge.
- R2: An edge-triggered pin is queued once per 0-to-1 change of its request-seen bit. Holding the input asserted produces no further delivery.
- R3: A level-triggered pin with remote-busy clear is queued while asserted, and its remote-busy bit is set when it is granted. While remote-busy is set, a new assertion is not delivered and pulses that pin's coalesced bit instead.
- R4: A new rising edge on an edge-triggered pin whose previous request is still pending and not being granted is merged into that request and pulses the pin's coalesced bit.
- R5: A masked pin is never queued and produces no delivery.
- R6: An entry write clears that pin's remote-busy bit. If the new entry is unmasked and level-triggered and the request-seen bit is set, the pin is queued in the same edge as the write.
- R7: A request from pin 0 carries destination mode 0 (physical) and the boot_dest value as destination. Other pins carry their entry's destination and mode.
- R8: When several pins are pending, the lowest-numbered one is granted first. The others stay pending for later slots.
- R9: While req_valid is high and req_ready is low, every request field holds its value.
- R10: After reset there is no valid request and no coalesced pulse, and every entry is masked.
- R11: An entry write word is laid out from bit 0 upward as: vector [7:0], delivery mode [10:8], destination mode [11], polarity [12], level trigger [13], mask [14], destination [22:15].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | NPINS | Raw interrupt input levels |
| boot_dest | input | 8 | Destination substituted for pin 0 |
| ent_we | input | 1 | Entry write strobe |
| ent_idx | input | IDX_W | Entry index to write |
| ent_wdata | input | 23 | Entry word (layout in R11) |
| req_valid | output | 1 | Delivery request valid |
| req_ready | input | 1 | Consumer accepts the request |
| req_pin | output | IDX_W | Source pin of the request |
| req_vector | output | 8 | Vector |
| req_dest | output | 8 | Destination |
| req_dest_mode | output | 1 | 0 physical, 1 logical |
| req_dlv_mode | output | 3 | Delivery mode |
| req_trig_lvl | output | 1 | 1 level, 0 edge |
| coal_pulse | output | NPINS | One-cycle coalesced indication per pin |

## Verification
A pin change driven before clock edge N is registered at N: request-seen, pending state and the coalesced pulse are all visible after N. The delivery request appears after edge N+1 if the output slot is free. An entry write at edge N that re-queues a level pin shows its request after N+1. An accepted request is replaced or dropped at the accepting edge. The bench drives every input just after a falling edge, steps one rising edge at a time and samples at the next falling edge, so each check lands in the cycle these counts predict.

// File: rtl/irq_pd_pkg.sv
package irq_pd_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int DLV_W  = 3;
  localparam int ENT_W  = VEC_W + DLV_W + 4 + DEST_W;

  // routing entry, MSB first
  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              lvl;
    logic              pol;
    logic              dmode;
    logic [DLV_W-1:0]  dlv;
    logic [VEC_W-1:0]  vec;
  } ent_t;

  localparam ent_t ENT_RST = '{dest: '0, mask: 1'b1, lvl: 1'b0, pol: 1'b0,
                               dmode: 1'b0, dlv: '0, vec: '0};
endpackage

// File: rtl/irq_pd_ent_tbl.sv
module irq_pd_ent_tbl import irq_pd_pkg::*; #(
  parameter int NPINS = 8,
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IDX_W-1:0]       widx,
  input  ent_t                   wdata,
  output ent_t [NPINS-1:0]       ents
);
  ent_t tbl [NPINS];

  // every entry is read in parallel, so each slot is its own register
  for (genvar g = 0; g < NPINS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        tbl[g] <= ENT_RST;
      else if (we && widx == IDX_W'(g))
        tbl[g] <= wdata;
    end
    assign ents[g] = tbl[g];
  end
endmodule

// File: rtl/irq_pd_pin_ctl.sv
module irq_pd_pin_ctl (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic pol,
  input  logic lvl,
  input  logic mask,
  input  logic wr_hit,
  input  logic wr_lvl,
  input  logic wr_mask,
  input  logic grant,
  output logic pend,
  output logic coal
);
  logic irr, rirr;
  logic eff, rise, svc, coal_ev;

  always_comb begin
    eff     = raw ^ pol;
    rise    = eff & ~irr;
    svc     = ~wr_hit & (lvl ? (eff & ~rirr) : rise);
    coal_ev = ~wr_hit & rise &
              (lvl ? rirr : (pend & ~grant & ~mask));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr  <= 1'b0;
      rirr <= 1'b0;
      pend <= 1'b0;
      coal <= 1'b0;
    end else begin
      irr  <= eff;
      coal <= coal_ev;
      if (wr_hit) begin
        rirr <= 1'b0;
        pend <= ~wr_mask & (pend | (wr_lvl & irr));
      end else begin
        if (grant && lvl) rirr <= 1'b1;
        pend <= (pend & ~grant) | (svc & ~mask & ~(grant & lvl));
      end
    end
  end

  // R5: a masked pin holds no pending request
  a_r5_masked_not_pending: assert property (@(posedge clk) disable iff (rst)
    mask |-> !pend);
  // R3: granting a level pin sets remote-busy
  a_r3_busy_after_grant: assert property (@(posedge clk) disable iff (rst)
    (grant && lvl && !wr_hit) |=> rirr);
  // R3: no new queueing of a level pin while remote-busy
  a_r3_no_requeue_busy: assert property (@(posedge clk) disable iff (rst)
    (rirr && lvl && !pend && !wr_hit) |=> !pend);
endmodule

// File: rtl/irq_pd_pick.sv
module irq_pd_pick #(
  parameter int NPINS = 8,
  parameter int IDX_W = 3
) (
  input  logic [NPINS-1:0] req,
  output logic [NPINS-1:0] onehot,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    any    = |req;
    onehot = any ? (NPINS'(1) << idx) : '0;
  end
endmodule

// File: rtl/irq_pd_deliver.sv
module irq_pd_deliver import irq_pd_pkg::*; #(
  parameter int NPINS = 8,
  parameter int IDX_W = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NPINS-1:0]              pend,
  input  logic [NPINS-1:0][VEC_W-1:0]   vecs,
  input  logic [NPINS-1:0][DEST_W-1:0]  dests,
  input  logic [NPINS-1:0]              dmodes,
  input  logic [NPINS-1:0][DLV_W-1:0]   dlvs,
  input  logic [NPINS-1:0]              lvls,
  input  logic [DEST_W-1:0]             boot_dest,
  input  logic                          ready,
  output logic [NPINS-1:0]              grant,
  output logic                          valid,
  output logic [IDX_W-1:0]              o_pin,
  output logic [VEC_W-1:0]              o_vec,
  output logic [DEST_W-1:0]             o_dest,
  output logic                          o_dmode,
  output logic [DLV_W-1:0]              o_dlv,
  output logic                          o_lvl
);
  logic [NPINS-1:0] sel_oh;
  logic [IDX_W-1:0] sel;
  logic             any, load, boot_pin;

  irq_pd_pick #(.NPINS(NPINS), .IDX_W(IDX_W)) u_pick (
    .req(pend), .onehot(sel_oh), .idx(sel), .any(any));

  always_comb begin
    load     = any & (~valid | ready);
    grant    = load ? sel_oh : '0;
    boot_pin = (sel == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      o_pin   <= '0;
      o_vec   <= '0;
      o_dest  <= '0;
      o_dmode <= 1'b0;
      o_dlv   <= '0;
      o_lvl   <= 1'b0;
    end else if (load) begin
      valid   <= 1'b1;
      o_pin   <= sel;
      o_vec   <= vecs[sel];
      o_dest  <= boot_pin ? boot_dest : dests[sel];
      o_dmode <= boot_pin ? 1'b0 : dmodes[sel];
      o_dlv   <= dlvs[sel];
      o_lvl   <= lvls[sel];
    end else if (ready) begin
      valid   <= 1'b0;
    end
  end

  // R8: at most one pin granted per edge
  a_r8_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R8: no lower-numbered pin left waiting behind a grant
  a_r8_lowest_first: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |-> ((pend & (grant - NPINS'(1))) == '0));
  // R9: request held while stalled
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(o_pin) && $stable(o_vec) &&
                           $stable(o_dest) && $stable(o_dmode) &&
                           $stable(o_dlv) && $stable(o_lvl)));
endmodule

// File: rtl/irq_pin_dispatch.sv
module irq_pin_dispatch import irq_pd_pkg::*; #(
  parameter int NPINS = 8,
  parameter int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_raw,
  input  logic [DEST_W-1:0] boot_dest,
  input  logic              ent_we,
  input  logic [IDX_W-1:0]  ent_idx,
  input  logic [ENT_W-1:0]  ent_wdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [IDX_W-1:0]  req_pin,
  output logic [VEC_W-1:0]  req_vector,
  output logic [DEST_W-1:0] req_dest,
  output logic              req_dest_mode,
  output logic [DLV_W-1:0]  req_dlv_mode,
  output logic              req_trig_lvl,
  output logic [NPINS-1:0]  coal_pulse
);
  ent_t                         wr_ent;
  ent_t [NPINS-1:0]             ents;
  logic [NPINS-1:0]             pend, grant;
  logic [NPINS-1:0][VEC_W-1:0]  vecs;
  logic [NPINS-1:0][DEST_W-1:0] dests;
  logic [NPINS-1:0]             dmodes, lvls;
  logic [NPINS-1:0][DLV_W-1:0]  dlvs;

  assign wr_ent = ent_t'(ent_wdata);

  irq_pd_ent_tbl #(.NPINS(NPINS), .IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst(rst), .we(ent_we), .widx(ent_idx),
    .wdata(wr_ent), .ents(ents));

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign vecs[g]   = ents[g].vec;
    assign dests[g]  = ents[g].dest;
    assign dmodes[g] = ents[g].dmode;
    assign dlvs[g]   = ents[g].dlv;
    assign lvls[g]   = ents[g].lvl;

    irq_pd_pin_ctl u_ctl (
      .clk(clk), .rst(rst), .raw(pin_raw[g]),
      .pol(ents[g].pol), .lvl(ents[g].lvl), .mask(ents[g].mask),
      .wr_hit(ent_we && ent_idx == IDX_W'(g)),
      .wr_lvl(wr_ent.lvl), .wr_mask(wr_ent.mask),
      .grant(grant[g]), .pend(pend[g]), .coal(coal_pulse[g]));
  end

  irq_pd_deliver #(.NPINS(NPINS), .IDX_W(IDX_W)) u_dlv (
    .clk(clk), .rst(rst), .pend(pend), .vecs(vecs), .dests(dests),
    .dmodes(dmodes), .dlvs(dlvs), .lvls(lvls), .boot_dest(boot_dest),
    .ready(req_ready), .grant(grant), .valid(req_valid),
    .o_pin(req_pin), .o_vec(req_vector), .o_dest(req_dest),
    .o_dmode(req_dest_mode), .o_dlv(req_dlv_mode), .o_lvl(req_trig_lvl));

  // R7: pin 0 always leaves in physical mode
  a_r7_boot_physical: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_pin == '0) |-> !req_dest_mode);
  // R10: no coalesced pulse in the first cycle after reset
  a_r10_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (coal_pulse == '0 && !req_valid));
endmodule

// File: tb/irq_pin_dispatch_bench.sv
module irq_pin_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pin_raw = 8'h00;
  logic [7:0]  boot_dest = 8'h0B;
  logic        ent_we = 1'b0;
  logic [2:0]  ent_idx = 3'd0;
  logic [22:0] ent_wdata = '0;
  logic        req_ready = 1'b1;
  logic        req_valid, req_dest_mode, req_trig_lvl;
  logic [2:0]  req_pin, req_dlv_mode;
  logic [7:0]  req_vector, req_dest, coal_pulse;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_pin_dispatch u_irq_pin_dispatch (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .boot_dest(boot_dest),
    .ent_we(ent_we), .ent_idx(ent_idx), .ent_wdata(ent_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_pin(req_pin),
    .req_vector(req_vector), .req_dest(req_dest),
    .req_dest_mode(req_dest_mode), .req_dlv_mode(req_dlv_mode),
    .req_trig_lvl(req_trig_lvl), .coal_pulse(coal_pulse));

  // {pins, exp_valid, exp_pin, exp_vec, exp_trig, exp_coal}
  localparam logic [28:0] TBL [0:11] = '{
    {8'h08, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00},
    {8'h0A, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00},
    {8'h0A, 1'b1, 3'd1, 8'h31, 1'b0, 8'h00},
    {8'h0A, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00},
    {8'h0C, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00},
    {8'h0C, 1'b1, 3'd2, 8'h42, 1'b1, 8'h00},
    {8'h0C, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00},
    {8'h08, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00},
    {8'h0C, 1'b0, 3'd0, 8'h00, 1'b0, 8'h04},
    {8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00},
    {8'h00, 1'b1, 3'd3, 8'h53, 1'b0, 8'h00},
    {8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R11 layout: dest[22:15] mask[14] lvl[13] pol[12] dmode[11] dlv[10:8] vec[7:0]
  task automatic wr(input logic [2:0] idx, input logic [7:0] vec, input logic dmode,
                    input logic pol, input logic lvl, input logic mask, input logic [7:0] dest);
    ent_we    = 1'b1;
    ent_idx   = idx;
    ent_wdata = {dest, mask, lvl, pol, dmode, 3'd1, vec};
    tick();
    ent_we    = 1'b0;
  endtask

  task automatic exp_req(input string tag, input logic [2:0] pin, input logic [7:0] vec);
    check({tag, " valid"}, 32'(req_valid), 32'd1);
    check({tag, " pin"}, 32'(req_pin), 32'(pin));
    check({tag, " vector"}, 32'(req_vector), 32'(vec));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    check("R10 reset valid", 32'(req_valid), 32'd0);
    check("R10 reset coal", 32'(coal_pulse), 32'd0);
    // R10: all entries masked after reset
    pin_raw = 8'hFF;
    repeat (3) tick();
    check("R10 masked after reset", 32'(req_valid), 32'd0);
    pin_raw = 8'h08;
    tick(); tick();

    wr(3'd1, 8'h31, 1'b1, 1'b0, 1'b0, 1'b0, 8'h05);
    wr(3'd2, 8'h42, 1'b0, 1'b0, 1'b1, 1'b0, 8'h06);
    wr(3'd3, 8'h53, 1'b0, 1'b1, 1'b0, 1'b0, 8'h07);

    // R1/R2/R3 table walk
    for (int k = 0; k < 12; k++) begin
      pin_raw = TBL[k][28:21];
      tick();
      check($sformatf("R1/R2/R3 row %0d valid", k), 32'(req_valid), 32'(TBL[k][20]));
      if (TBL[k][20]) begin
        check($sformatf("R1/R2/R3 row %0d pin", k), 32'(req_pin), 32'(TBL[k][19:17]));
        check($sformatf("R1/R2/R3 row %0d vector", k), 32'(req_vector), 32'(TBL[k][16:9]));
        check($sformatf("R1/R2/R3 row %0d trig", k), 32'(req_trig_lvl), 32'(TBL[k][8]));
      end
      check($sformatf("R1/R2/R3 row %0d coal", k), 32'(coal_pulse), 32'(TBL[k][7:0]));
    end

    // R4 and R9: merged edge while stalled
    req_ready = 1'b0;
    pin_raw = 8'h02; tick(); tick();
    exp_req("R9 stalled request", 3'd1, 8'h31);
    pin_raw = 8'h00; tick();
    pin_raw = 8'h02; tick();
    check("R4 first pending no coal", 32'(coal_pulse), 32'd0);
    pin_raw = 8'h00; tick();
    pin_raw = 8'h02; tick();
    check("R4 merged edge coal", 32'(coal_pulse), 32'h02);
    exp_req("R9 held while not ready", 3'd1, 8'h31);
    req_ready = 1'b1; tick();
    exp_req("R4 one queued after accept", 3'd1, 8'h31);
    tick();
    check("R4 merged to single", 32'(req_valid), 32'd0);

    // R8: simultaneous edges on pins 1 and 3
    pin_raw = 8'h08; tick(); tick();
    pin_raw = 8'h02; tick(); tick();
    exp_req("R8 lowest first", 3'd1, 8'h31);
    check("R7 other pin dest", 32'(req_dest), 32'h05);
    check("R7 other pin mode", 32'(req_dest_mode), 32'd1);
    tick();
    exp_req("R8 second pin later", 3'd3, 8'h53);
    tick();
    check("R8 queue drained", 32'(req_valid), 32'd0);

    // R5: masked edge pin
    wr(3'd4, 8'h64, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    pin_raw = 8'h12; tick(); tick(); tick();
    check("R5 masked no delivery", 32'(req_valid), 32'd0);

    // R3 busy then R6 rewrite
    pin_raw = 8'h16; tick();
    check("R3 busy coal", 32'(coal_pulse), 32'h04);
    tick();
    check("R3 busy no delivery", 32'(req_valid), 32'd0);
    wr(3'd2, 8'h42, 1'b0, 1'b0, 1'b1, 1'b1, 8'h06);
    tick(); tick();
    check("R5 masked rewrite no delivery", 32'(req_valid), 32'd0);
    wr(3'd2, 8'h42, 1'b0, 1'b0, 1'b1, 1'b0, 8'h06);
    tick();
    exp_req("R6 rewrite requeues level", 3'd2, 8'h42);
    tick();
    check("R6 single delivery", 32'(req_valid), 32'd0);

    // R7: pin 0 override
    wr(3'd0, 8'h20, 1'b1, 1'b0, 1'b0, 1'b0, 8'h77);
    pin_raw = 8'h17; tick(); tick();
    exp_req("R7 pin0 request", 3'd0, 8'h20);
    check("R7 pin0 dest", 32'(req_dest), 32'h0B);
    check("R7 pin0 physical", 32'(req_dest_mode), 32'd0);
    tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule